// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits in an always-on power domain next to a generic interrupt controller. It takes a vector of shared peripheral interrupt lines and forwards each line straight to the downstream controller, whatever the enable settings are. Two external pins, which are active low, are inverted on the way so that the controller sees every line as active high.

The block also keeps a set of enable registers for each of two CPUs. When a line is asserted and that CPU's enable bit for the line is set, the block raises a registered wakeup request to that CPU. Software sets up the enables through a small memory-mapped port that has a request, a write flag, a byte address and 32-bit data. A read returns the addressed enable word on the following cycle.

The number of handled interrupts is a parameter, and the register count follows from it. With the default of 160 interrupts, each CPU has five enable words.

Top module: `wake_gen`

## Requirements
- R1: The CPU number is address bit 10, so each CPU's bank starts at byte offset CPU × 0x400. Address bits 9:2 give the word index. When a request is made with the write flag low, the addressed word appears on `bus_rdata` with `bus_rvld` high one cycle later. A write replaces the whole word.
- R2: After reset every enable word of both CPUs reads as zero and both wakeup outputs are low.
- R3: Interrupt n is controlled by bit n mod 32 of word n>>5 in the CPU's bank.
- R4: `wake[c]` is a registered output. It is high in the cycle after some line below NUM_IRQS is asserted (after normalisation) while its enable bit for CPU c is set, and low otherwise. Writing all ones to every word of a bank enables every interrupt of that CPU.
- R5: `irq_out[n]` equals `irq_in[n]` for every line other than the two inverted pins, independent of any enable bit, with no register on the path.
- R6: Lines 7 and 119 are active low. `irq_out` carries their inverse, and for wakeup they count as asserted when their input is low.
- R7: Lines at index NUM_IRQS or above never cause a wakeup, and they are forwarded unchanged.
- R8: A word index of NUM_IRQS/32 rounded up or more, or an address whose bits 1:0 are not zero, reads as zero, and a write to such an address changes no enable word.
- R9: A write to one CPU's bank leaves the other CPU's bank unchanged.
- R10: With `bus_req` low, `bus_wr` and the other port inputs change no enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on domain |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address: bit 10 selects the CPU, bits 9:2 give the word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvld | output | 1 | Read data valid |
| irq_in | input | IRQ_LINES | Incoming interrupt lines |
| irq_out | output | IRQ_LINES | Lines forwarded to the downstream controller |
| wake | output | 2 | Registered wakeup request for each CPU |

## Verification
The main sweep asserts each line on its own, once with every enable bit of one CPU set and once with only that line's own enable bit cleared. The first case separates lines that can wake a CPU from those above the interrupt count and shows which CPU gets the request. The second case shows that word n>>5 and bit n mod 32 are wired to line n and to no other. Pass-through is tried with several mixed patterns, including all lines low and all lines high, under both empty and full enables, so that the effect of the two inverted pins can be seen apart from the other lines. Distinct data patterns are written to every word of both banks, and writes are made to out-of-range and misaligned addresses, to check address decoding and that the two banks are kept apart.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
  localparam int NUM_CPUS = 2;
  localparam int WORD_W   = 32;
  localparam int CPU_BIT  = 10;           // bank stride 0x400
  localparam int IDX_W    = CPU_BIT - 2;  // word index bits 9:2

  function automatic int banks_for(input int n_irqs);
    return (n_irqs + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int word_of(input int n);
    return n / WORD_W;
  endfunction

  function automatic int bit_of(input int n);
    return n % WORD_W;
  endfunction
endpackage

// File: rtl/wkg_enable_bank.sv
module wkg_enable_bank import wkg_pkg::*; #(
  parameter int BANKS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [BANKS*WORD_W-1:0] en_flat
);
  for (genvar b = 0; b < BANKS; b++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        en_flat[b*WORD_W +: WORD_W] <= '0;
      else if (we && idx == IDX_W'(b))
        en_flat[b*WORD_W +: WORD_W] <= wdata;
    end
  end
endmodule

// File: rtl/wkg_wake_reduce.sv
module wkg_wake_reduce #(
  parameter int N = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] en,
  output logic         hit,
  output logic         wake
);
  assign hit = |(lines & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= hit;
  end
endmodule

// File: rtl/wkg_forward.sv
module wkg_forward #(
  parameter int LINES = 192,
  parameter int PIN_A = 7,
  parameter int PIN_B = 119
) (
  input  logic [LINES-1:0] irq_in,
  output logic [LINES-1:0] irq_out
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == PIN_A || i == PIN_B) begin : g_inv
      assign irq_out[i] = ~irq_in[i];
    end else begin : g_thru
      assign irq_out[i] = irq_in[i];
    end
  end
endmodule

// File: rtl/wake_gen.sv
module wake_gen import wkg_pkg::*; #(
  parameter int NUM_IRQS  = 160,
  parameter int IRQ_LINES = 192,
  parameter int INV_PIN_A = 7,
  parameter int INV_PIN_B = 119
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic [CPU_BIT:0]     bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_rvld,
  input  logic [IRQ_LINES-1:0] irq_in,
  output logic [IRQ_LINES-1:0] irq_out,
  output logic [NUM_CPUS-1:0]  wake
);
  localparam int BANKS = banks_for(NUM_IRQS);
  localparam int EN_W  = BANKS * WORD_W;
  localparam logic [IDX_W-1:0] BANKS_IDX = IDX_W'(BANKS);

  logic [IDX_W-1:0]           idx;
  logic                       cpu_sel;
  logic                       oob;
  logic [EN_W-1:0]            en_bus [NUM_CPUS];
  logic [NUM_CPUS*EN_W-1:0]   en_all;
  logic [NUM_CPUS-1:0]        hit;

  assign idx     = bus_addr[CPU_BIT-1:2];
  assign cpu_sel = bus_addr[CPU_BIT];
  assign oob     = (idx >= BANKS_IDX) || (bus_addr[1:0] != 2'b00);

  function automatic logic [WORD_W-1:0] word_pick(input logic [EN_W-1:0] v,
                                                  input logic [IDX_W-1:0] i);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int b = 0; b < BANKS; b++)
      if (i == IDX_W'(b)) r = v[b*WORD_W +: WORD_W];
    return r;
  endfunction

  wkg_forward #(.LINES(IRQ_LINES), .PIN_A(INV_PIN_A), .PIN_B(INV_PIN_B)) u_fwd (
    .irq_in (irq_in),
    .irq_out(irq_out)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic we_c;
    assign we_c = bus_req && bus_wr && !oob && (cpu_sel == 1'(c));

    wkg_enable_bank #(.BANKS(BANKS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we_c),
      .idx    (idx),
      .wdata  (bus_wdata),
      .en_flat(en_bus[c])
    );

    wkg_wake_reduce #(.N(NUM_IRQS)) u_red (
      .clk  (clk),
      .rst_n(rst_n),
      .lines(irq_out[NUM_IRQS-1:0]),
      .en   (en_bus[c][NUM_IRQS-1:0]),
      .hit  (hit[c]),
      .wake (wake[c])
    );

    assign en_all[c*EN_W +: EN_W] = en_bus[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_rvld  <= 1'b0;
    end else begin
      bus_rvld <= bus_req && !bus_wr;
      if (bus_req && !bus_wr)
        bus_rdata <= oob ? '0 : word_pick(en_bus[cpu_sel], idx);
    end
  end
endmodule

// File: rtl/wkg_checks.sv
module wkg_checks #(
  parameter int IRQ_LINES = 192,
  parameter int EN_W      = 160,
  parameter int INV_PIN_A = 7,
  parameter int INV_PIN_B = 119
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   bus_wr,
  input logic                   wr_cpu,
  input logic                   oob,
  input logic [31:0]            bus_rdata,
  input logic                   bus_rvld,
  input logic [IRQ_LINES-1:0]   irq_in,
  input logic [IRQ_LINES-1:0]   irq_out,
  input logic [1:0]             hit,
  input logic [1:0]             wake,
  input logic [2*EN_W-1:0]      en_all
);
  function automatic logic [IRQ_LINES-1:0] pin_mask();
    logic [IRQ_LINES-1:0] m;
    m = '0;
    m[INV_PIN_A] = 1'b1;
    m[INV_PIN_B] = 1'b1;
    return m;
  endfunction
  localparam logic [IRQ_LINES-1:0] PINS = pin_mask();

  assert_read_follows_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvld |-> $past(bus_req && !bus_wr));

  assert_oob_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && oob) |=> (bus_rdata == 32'd0));

  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_hit_raises_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |=> wake[c]);
    assert_no_hit_no_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[c] |=> !wake[c]);
  end

  assert_pins_inverted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out ^ irq_in) & PINS) == PINS);

  assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out ^ irq_in) & ~PINS) == '0);

  assert_cpu1_bank_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && !wr_cpu) |=> $stable(en_all[2*EN_W-1:EN_W]));

  assert_cpu0_bank_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && wr_cpu) |=> $stable(en_all[EN_W-1:0]));

  assert_idle_port_keeps_banks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> $stable(en_all));
endmodule

bind wake_gen wkg_checks #(
  .IRQ_LINES(IRQ_LINES), .EN_W(EN_W), .INV_PIN_A(INV_PIN_A), .INV_PIN_B(INV_PIN_B)
) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_wr   (bus_wr),
  .wr_cpu   (cpu_sel),
  .oob      (oob),
  .bus_rdata(bus_rdata),
  .bus_rvld (bus_rvld),
  .irq_in   (irq_in),
  .irq_out  (irq_out),
  .hit      (hit),
  .wake     (wake),
  .en_all   (en_all)
);

// File: tb/tb_wake_gen.sv
module tb_wake_gen;
  localparam int NI = 160;
  localparam int NL = 192;
  localparam int NB = (NI + 31) / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, wr = 1'b0;
  logic [10:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvld;
  logic [NL-1:0] irq_raw;
  logic [NL-1:0] irq_fwd;
  logic [1:0]    wake;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvld(rvld),
    .irq_in(irq_raw), .irq_out(irq_fwd), .wake(wake)
  );

  function automatic logic [NL-1:0] low_pins();
    logic [NL-1:0] m = '0;
    m[7] = 1'b1;
    m[119] = 1'b1;
    return m;
  endfunction

  // raw pin levels that present the given active-high vector downstream
  function automatic logic [NL-1:0] to_raw(input logic [NL-1:0] v);
    return v ^ low_pins();
  endfunction

  function automatic logic [31:0] pat(input int c, input int i);
    return 32'h5A3C_0000 ^ (32'(c) << 20) ^ (32'(i + 1) * 32'h0001_0203);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NL-1:0] act,
                     input logic [NL-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int c, input int i, input logic [31:0] d,
                           input logic [1:0] lo = 2'b00);
    req = 1'b1; wr = 1'b1; addr = {c[0], i[7:0], lo}; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input int c, input int i, output logic [31:0] d,
                          input logic [1:0] lo = 2'b00);
    req = 1'b1; wr = 1'b0; addr = {c[0], i[7:0], lo};
    @(negedge clk);
    d = rdata;
    chk(rvld === 1'b1, "R1 read valid", NL'(rvld), NL'(1));
    req = 1'b0;
  endtask

  task automatic fill(input int c, input logic [31:0] d);
    for (int i = 0; i < NB; i++) bus_write(c, i, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NL-1:0] v;
    logic [NL-1:0] pats [4];
    irq_raw = to_raw('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    chk(wake == 2'b00, "R2 wake after reset", NL'(wake), '0);
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NB; i++) begin
        bus_read(c, i, d);
        chk(d == 32'd0, "R2 enable word after reset", NL'(d), '0);
      end

    // R1 / R9: distinct data per word and CPU
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NB; i++) bus_write(c, i, pat(c, i));
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NB; i++) begin
        bus_read(c, i, d);
        chk(d == pat(c, i), "R1 R9 readback per CPU bank", NL'(d), NL'(pat(c, i)));
      end

    // R10: write flag without request
    wr = 1'b1; addr = 11'h000; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    wr = 1'b0;
    bus_read(0, 0, d);
    chk(d == pat(0, 0), "R10 idle port no change", NL'(d), NL'(pat(0, 0)));

    // R8: out of range and misaligned
    bus_write(0, NB, 32'hFFFF_FFFF);
    bus_write(1, 0, 32'hFFFF_FFFF, 2'b01);
    bus_read(0, NB, d);
    chk(d == 32'd0, "R8 out-of-range read zero", NL'(d), '0);
    bus_read(0, 255, d);
    chk(d == 32'd0, "R8 top index read zero", NL'(d), '0);
    bus_read(1, 0, d, 2'b10);
    chk(d == 32'd0, "R8 misaligned read zero", NL'(d), '0);
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NB; i++) begin
        bus_read(c, i, d);
        chk(d == pat(c, i), "R8 ignored write kept banks", NL'(d), NL'(pat(c, i)));
      end

    // R5 / R6: pass-through independent of enables
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {6{32'hA5A5_0F0F}};
    pats[3] = {6{32'h1234_8001}};
    for (int e = 0; e < 2; e++) begin
      fill(0, e ? 32'hFFFF_FFFF : 32'h0);
      fill(1, 32'h0);
      for (int p = 0; p < 4; p++) begin
        irq_raw = pats[p];
        #1;
        chk(irq_fwd == (pats[p] ^ low_pins()), "R5 R6 forwarded lines", irq_fwd,
            pats[p] ^ low_pins());
        @(negedge clk);
      end
    end
    // R6: active-low pins wake when low
    irq_raw = '0;
    @(negedge clk);
    chk(wake == 2'b01, "R6 low pins wake CPU0", NL'(wake), NL'(2'b01));
    irq_raw = low_pins();
    @(negedge clk);
    chk(wake == 2'b00, "R6 high pins idle", NL'(wake), '0);

    // R4: one-cycle latency
    irq_raw = to_raw(NL'(1));
    #1;
    chk(wake == 2'b00, "R4 no wake in same cycle", NL'(wake), '0);
    @(negedge clk);
    chk(wake == 2'b01, "R4 wake next cycle", NL'(wake), NL'(2'b01));
    irq_raw = to_raw('0);
    @(negedge clk);

    // R3 / R4 / R7: per-line sweep for each CPU
    for (int c = 0; c < 2; c++) begin
      fill(0, 32'h0);
      fill(1, 32'h0);
      fill(c, 32'hFFFF_FFFF);
      for (int n = 0; n < NL; n++) begin
        logic [1:0] expw;
        v = '0;
        v[n] = 1'b1;
        irq_raw = to_raw(v);
        @(negedge clk);
        expw = (n < NI) ? (2'b01 << c) : 2'b00;
        chk(wake == expw, "R4 R7 single line wake", NL'(wake), NL'(expw));
        chk(irq_fwd == v, "R7 R6 single line forwarded", irq_fwd, v);
        if (n < NI) begin
          bus_write(c, n / 32, ~(32'd1 << (n % 32)));
          @(negedge clk);
          chk(wake == 2'b00, "R3 own enable bit cleared", NL'(wake), '0);
          bus_write(c, n / 32, 32'hFFFF_FFFF);
        end
        irq_raw = to_raw('0);
        @(negedge clk);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule